// File: doc/BRIEF.md
# Subtractive Block-Signature Control-Flow Monitor

This block sits beside a processor's instruction fetch path and checks that every branch-free run of code executes without corruption. Branch-free means no jump enters or leaves the middle of the run. The compiler places a tagged reference word at the head of each such run. That word holds the sum of the run's instruction codes, and the processor executes it as a no-operation. The monitor loads the reference into an accumulator that is wider than the instruction word. It subtracts every later fetched code from it. When the tagged end marker arrives, the accumulator must read exactly zero.

The monitor also serves as a watchdog timer. If the running difference goes below zero before the end marker, too many instruction codes (or too large ones) have been fetched, and an error is raised at once. No separate timer is needed. Fetches that fall outside any open run are errors, and so are runs that are never closed. Each error produces a one-cycle pulse and sets a status code. The status code holds until software-side logic strobes the clear input.

Top module: `block_sig_monitor`

## Requirements
- R1: A fetch with `fetch_vld`=1, `tag_ref`=1 and `tag_end`=0 opens a run. It loads `fetch_code`, zero-extended, into the accumulator and is not itself subtracted.
- R2: While a run is open, every untagged valid fetch subtracts `fetch_code` from the accumulator. A run whose codes sum exactly to the reference closes on the end marker (`tag_end`=1, `tag_ref`=0) with no error, and the end marker itself is not subtracted.
- R3: An end marker that arrives while the accumulator is nonzero raises status code 1 (nonzero at end) and closes the run.
- R4: An untagged fetch that makes the accumulator negative (sign bit of the accumulator, which is GUARD bits wider than the code) raises status code 2 (went negative) on that fetch, without waiting for the end marker.
- R5: After a negative trip, the run is abandoned. Further untagged fetches and the next end marker raise no error, and a later reference opens a fresh run.
- R6: An untagged fetch or an end marker while no run is open raises status code 3 (missing reference).
- R7: A reference tag while a run is open raises status code 4 (missing end) and loads the new reference as a fresh run.
- R8: A fetch carrying both tags is handled as an end marker for the current run (with the checks of R2, R3 and R6), then as a reference that opens a new run.
- R9: When `fetch_vld` is 0, the code and both tags are ignored.
- R10: `err_pulse` is high in exactly the one cycle after the clock edge that sampled the offending fetch.
- R11: `err_code` keeps the first error captured (code 0 = no error) until `status_clr`. A clear in the same cycle as a new error leaves the new error's code.
- R12: Reset clears the status to 0, drops `err_pulse` and leaves no run open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | An instruction fetch is present this cycle |
| fetch_code | input | CODE_W | Fetched instruction code or reference value |
| tag_ref | input | 1 | Fetched word is a run reference |
| tag_end | input | 1 | Fetched word is a run end marker |
| status_clr | input | 1 | Clears the sticky status code |
| err_pulse | output | 1 | One-cycle error strobe |
| err_code | output | 3 | Sticky status: 0 none, 1 nonzero at end, 2 negative, 3 missing reference, 4 missing end |

## Verification
The embedded assertions check several rules on every cycle. An open run never holds a negative accumulator. A reference load lands in the accumulator on the next edge. A stray fetch with no run open always yields a pulse. A nonzero status stays put when no clear is pending, and a lone clear empties it. Only the bench's scenarios can show the following: that a correctly summed run closes silently, the exact code chosen for each fault, that the abandoned run stays quiet, first-error priority, and the combined-tag ordering. These depend on whole sequences of fetches with known sums.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

   typedef enum logic [2:0] {
      ST_NONE      = 3'd0,
      ST_ZERO_FAIL = 3'd1,
      ST_NEG       = 3'd2,
      ST_NOREF     = 3'd3,
      ST_NOEND     = 3'd4
   } cfm_status_e;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_WORD,
      EV_REF,
      EV_END,
      EV_ENDREF
   } cfm_event_e;

   typedef enum logic [1:0] {
      RUN_IDLE,
      RUN_OPEN,
      RUN_ABORT
   } cfm_run_e;

endpackage

// File: rtl/cfm_decode.sv
module cfm_decode
   import cfm_pkg::*;
(
   input  logic       vld_i,
   input  logic       ref_i,
   input  logic       end_i,
   output cfm_event_e ev_o
);

   always_comb begin
      ev_o = EV_NONE;
      if (vld_i) begin
         unique case ({end_i, ref_i})
            2'b00:   ev_o = EV_WORD;
            2'b01:   ev_o = EV_REF;
            2'b10:   ev_o = EV_END;
            default: ev_o = EV_ENDREF;
         endcase
      end
   end

endmodule

// File: rtl/cfm_accum.sv
module cfm_accum #(
   parameter int CODE_W      = 16,
   parameter int GUARD       = 8,
   parameter bit NEG_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              sub_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              zero_o,
   output logic              trip_o,
   output logic              sign_o
);

   localparam int ACC_W = CODE_W + GUARD;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] code_ext;
   logic [ACC_W-1:0] diff;

   assign code_ext = {{GUARD{1'b0}}, code_i};
   assign diff     = acc_q - code_ext;
   assign zero_o   = (acc_q == '0);
   assign sign_o   = acc_q[ACC_W-1];

   generate
      if (NEG_CHECK_EN) begin : g_trip
         assign trip_o = diff[ACC_W-1];
      end else begin : g_no_trip
         assign trip_o = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (load_i) acc_q <= code_ext;
      else if (sub_i)  acc_q <= diff;
   end

   // R1: a reference load appears in the accumulator on the next edge
   assert_ref_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (acc_q == $past(code_ext)));

   // R2: a subtraction moves the accumulator by exactly the code
   assert_sub_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_i && !load_i) |=> (acc_q + $past(code_ext) == $past(acc_q)));

endmodule

// File: rtl/cfm_status.sv
module cfm_status
   import cfm_pkg::*;
#(
   parameter bit FIRST_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        err_i,
   input  cfm_status_e kind_i,
   input  logic        clr_i,
   output logic        pulse_o,
   output cfm_status_e code_o
);

   logic take;

   generate
      if (FIRST_WINS) begin : g_first
         assign take = err_i && (code_o == ST_NONE || clr_i);
      end else begin : g_last
         assign take = err_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_o <= 1'b0;
         code_o  <= ST_NONE;
      end else begin
         pulse_o <= err_i;
         if (take)       code_o <= kind_i;
         else if (clr_i) code_o <= ST_NONE;
      end
   end

   // R10: a pulse always comes with a recorded status
   assert_pulse_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (code_o != ST_NONE));

   // R11: a lone clear empties the status
   assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !err_i) |=> (code_o == ST_NONE));

   generate
      if (FIRST_WINS) begin : g_hold_chk
         // R11: without a clear the first captured code is held
         assert_code_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (code_o != ST_NONE && !clr_i) |=> $stable(code_o));
      end
   endgenerate

endmodule

// File: rtl/block_sig_monitor.sv
module block_sig_monitor
   import cfm_pkg::*;
#(
   parameter int CODE_W       = 16,
   parameter int GUARD        = 8,
   parameter bit NEG_CHECK_EN = 1'b1,
   parameter bit FIRST_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld,
   input  logic [CODE_W-1:0] fetch_code,
   input  logic              tag_ref,
   input  logic              tag_end,
   input  logic              status_clr,
   output logic              err_pulse,
   output logic [2:0]        err_code
);

   generate
      if (CODE_W < 1) begin : g_bad_code_w
         initial $error("CODE_W must be at least 1");
      end
      if (GUARD < 1) begin : g_bad_guard
         initial $error("GUARD must be at least 1 so a negative result is visible");
      end
   endgenerate

   cfm_event_e  ev;
   cfm_run_e    run_q, run_d;
   logic        load, sub, acc_zero, trip, acc_sign;
   logic        err;
   cfm_status_e kind;
   cfm_status_e code_q;

   cfm_decode u_decode (
      .vld_i (fetch_vld),
      .ref_i (tag_ref),
      .end_i (tag_end),
      .ev_o  (ev)
   );

   cfm_accum #(
      .CODE_W       (CODE_W),
      .GUARD        (GUARD),
      .NEG_CHECK_EN (NEG_CHECK_EN)
   ) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .sub_i  (sub),
      .code_i (fetch_code),
      .zero_o (acc_zero),
      .trip_o (trip),
      .sign_o (acc_sign)
   );

   always_comb begin
      run_d = run_q;
      load  = 1'b0;
      sub   = 1'b0;
      err   = 1'b0;
      kind  = ST_NONE;
      unique case (run_q)
         RUN_IDLE: begin
            unique case (ev)
               EV_WORD, EV_END: begin
                  err  = 1'b1;
                  kind = ST_NOREF;
               end
               EV_REF: begin
                  load  = 1'b1;
                  run_d = RUN_OPEN;
               end
               EV_ENDREF: begin
                  err   = 1'b1;
                  kind  = ST_NOREF;
                  load  = 1'b1;
                  run_d = RUN_OPEN;
               end
               default: ;
            endcase
         end
         RUN_OPEN: begin
            unique case (ev)
               EV_WORD: begin
                  sub = 1'b1;
                  if (trip) begin
                     err   = 1'b1;
                     kind  = ST_NEG;
                     run_d = RUN_ABORT;
                  end
               end
               EV_REF: begin
                  err  = 1'b1;
                  kind = ST_NOEND;
                  load = 1'b1;
               end
               EV_END: begin
                  run_d = RUN_IDLE;
                  if (!acc_zero) begin
                     err  = 1'b1;
                     kind = ST_ZERO_FAIL;
                  end
               end
               EV_ENDREF: begin
                  load = 1'b1;
                  if (!acc_zero) begin
                     err  = 1'b1;
                     kind = ST_ZERO_FAIL;
                  end
               end
               default: ;
            endcase
         end
         RUN_ABORT: begin
            unique case (ev)
               EV_REF, EV_ENDREF: begin
                  load  = 1'b1;
                  run_d = RUN_OPEN;
               end
               EV_END:  run_d = RUN_IDLE;
               default: ;
            endcase
         end
         default: run_d = RUN_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= RUN_IDLE;
      else        run_q <= run_d;
   end

   cfm_status #(
      .FIRST_WINS (FIRST_WINS)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_i   (err),
      .kind_i  (kind),
      .clr_i   (status_clr),
      .pulse_o (err_pulse),
      .code_o  (code_q)
   );

   assign err_code = code_q;

   // R6: a stray instruction with no run open always produces a pulse
   assert_stray_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_IDLE && ev == EV_WORD) |=> err_pulse);

   // R9: an idle fetch strobe never causes an error pulse
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_vld) |=> !err_pulse);

   generate
      if (NEG_CHECK_EN) begin : g_neg_chk
         // R4: an open run never carries a negative accumulator
         assert_open_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q == RUN_OPEN) |-> !acc_sign);
      end
   endgenerate

endmodule

// File: tb/block_sig_monitor_tb.sv
module block_sig_monitor_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_vld = 1'b0;
   logic [15:0] fetch_code = '0;
   logic        tag_ref = 1'b0;
   logic        tag_end = 1'b0;
   logic        status_clr = 1'b0;
   logic        err_pulse;
   logic [2:0]  err_code;

   int applied = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   block_sig_monitor u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_vld  (fetch_vld),
      .fetch_code (fetch_code),
      .tag_ref    (tag_ref),
      .tag_end    (tag_end),
      .status_clr (status_clr),
      .err_pulse  (err_pulse),
      .err_code   (err_code)
   );

   // row: {vld, ref, end, code[15:0], clr, exp_pulse, exp_code[2:0]}
   localparam int NV = 41;
   localparam logic [23:0] VEC [0:NV-1] = '{
      {3'b110, 16'h0030, 1'b0, 1'b0, 3'd0}, //  0 R1 open
      {3'b100, 16'h0010, 1'b0, 1'b0, 3'd0}, //  1 R2
      {3'b100, 16'h0020, 1'b0, 1'b0, 3'd0}, //  2 R2 reaches zero
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd0}, //  3 R2 clean end
      {3'b000, 16'h1234, 1'b0, 1'b0, 3'd0}, //  4 R9 gap
      {3'b110, 16'h0005, 1'b0, 1'b0, 3'd0}, //  5 R1
      {3'b100, 16'h0002, 1'b0, 1'b0, 3'd0}, //  6 R2
      {3'b101, 16'h0000, 1'b0, 1'b1, 3'd1}, //  7 R3 nonzero end
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, //  8 R11 clear
      {3'b100, 16'h0007, 1'b0, 1'b1, 3'd3}, //  9 R6 word no run
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, // 10 R11 clear
      {3'b110, 16'h0004, 1'b0, 1'b0, 3'd0}, // 11 R1
      {3'b100, 16'h0005, 1'b0, 1'b1, 3'd2}, // 12 R4 negative
      {3'b100, 16'h0001, 1'b0, 1'b0, 3'd2}, // 13 R5 abandoned word
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd2}, // 14 R5 quiet end
      {3'b110, 16'h0010, 1'b0, 1'b0, 3'd2}, // 15 R5 fresh run
      {3'b110, 16'h0010, 1'b0, 1'b1, 3'd2}, // 16 R7 + R11 first wins
      {3'b100, 16'h0010, 1'b0, 1'b0, 3'd2}, // 17 R7 new ref in use
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, // 18 R11 clear
      {3'b111, 16'h0003, 1'b0, 1'b0, 3'd0}, // 19 R8 close zero then open 3
      {3'b100, 16'h0003, 1'b0, 1'b0, 3'd0}, // 20 R8
      {3'b001, 16'h0000, 1'b0, 1'b0, 3'd0}, // 21 R9 tag without vld
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd0}, // 22 R8 run was still open
      {3'b101, 16'h0000, 1'b0, 1'b1, 3'd3}, // 23 R6 end no run
      {3'b000, 16'h0000, 1'b0, 1'b0, 3'd3}, // 24 R10 pulse one cycle
      {3'b100, 16'h0009, 1'b1, 1'b1, 3'd3}, // 25 R11 error beats clear
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, // 26 R11 clear
      {3'b110, 16'hFFFF, 1'b0, 1'b0, 3'd0}, // 27 R1 full range
      {3'b100, 16'hFFFF, 1'b0, 1'b0, 3'd0}, // 28 R2
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd0}, // 29 R2
      {3'b110, 16'h0001, 1'b0, 1'b0, 3'd0}, // 30 R1
      {3'b100, 16'hFFFF, 1'b0, 1'b1, 3'd2}, // 31 R4 deep negative
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, // 32 R11 clear
      {3'b110, 16'h0002, 1'b0, 1'b0, 3'd0}, // 33 R1
      {3'b110, 16'h0001, 1'b0, 1'b1, 3'd4}, // 34 R7 missing end
      {3'b100, 16'h0001, 1'b0, 1'b0, 3'd4}, // 35 R7
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd4}, // 36 R7 new ref summed to zero
      {3'b000, 16'h0000, 1'b1, 1'b0, 3'd0}, // 37 R11 clear
      {3'b111, 16'h0004, 1'b0, 1'b1, 3'd3}, // 38 R8 + R6 both tags no run
      {3'b100, 16'h0004, 1'b0, 1'b0, 3'd3}, // 39 R8 run opened anyway
      {3'b101, 16'h0000, 1'b0, 1'b0, 3'd3}  // 40 R8
   };

   task automatic drive(input logic v, input logic r, input logic e,
                        input logic [15:0] c, input logic cl);
      @(negedge clk);
      fetch_vld  = v;
      tag_ref    = r;
      tag_end    = e;
      fetch_code = c;
      status_clr = cl;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic ep, input logic [2:0] ec);
      applied++;
      if (err_pulse !== ep || err_code !== ec) begin
         miscompares++;
         $display("FAIL %s: pulse=%0b code=%0d expected pulse=%0b code=%0d",
                  req, err_pulse, err_code, ep, ec);
      end
   endtask

   initial begin
      #1_000_000;
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R12 reset state", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:5], VEC[i][4]);
         check($sformatf("vector %0d", i), VEC[i][3], VEC[i][2:0]);
      end

      // R12: reset mid-run leaves no run open
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
      drive(1'b1, 1'b1, 1'b0, 16'h0010, 1'b0);
      check("R12 run opened", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b0;
      fetch_vld = 1'b0;
      @(posedge clk);
      #1;
      check("R12 reset mid-run", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 16'h0001, 1'b0);
      check("R12 no run after reset (R6 code 3)", 1'b1, 3'd3);

      // R10: back-to-back errors pulse on consecutive cycles, then drop
      drive(1'b1, 1'b0, 1'b0, 16'h0002, 1'b0);
      check("R10 second stray word", 1'b1, 3'd3);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
      check("R10 pulse ends", 1'b0, 3'd3);

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

endmodule